// File: doc/BRIEF.md
# TDM Serial Bus Channel Adapter

This block sits between a 32-timeslot time-division-multiplexed serial bus and a 24-channel byte-wide interface inside the chip. The bus carries 125 µs frames of 32 eight-bit timeslots at 2048 kbit/s. A frame pulse input marks the start of each frame. The bus clock and frame pulse arrive as levels that are already synchronous to the core clock. The block detects the edges of the bus clock and does all of its work in the core clock domain.

On the receive side, serial input bits are taken on each falling edge of the bus clock, most significant bit first. Once a timeslot is complete, its byte is handed out as a one-cycle strobe, together with the index of the line channel it belongs to. Only 24 timeslots carry payload; the block drops the bytes of the other eight.

On the transmit side, the 24 channel bytes are presented as one wide parallel vector. The serial output moves to a new bit only on a rising edge of the bus clock. In the eight slots that carry no payload, the output is held at the idle value 0xFF, so the line is driven in every slot.

Top module: `tdm_chan_adapter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tdm_dout` is 1 and `rx_valid` is 0.
- R2: Each timeslot's byte is assembled from the `tdm_din` values sampled at eight consecutive bus-clock falling edges. The first bit received is bit 7 of `rx_data`. The byte is presented for exactly one core cycle with `rx_valid` high.
- R3: Line channel n (0..23) corresponds to bus timeslot n + floor(n/3) + 1. Slots 0, 4, 8, …, 28 (multiples of 4) are unused. Exactly 24 bytes are delivered per aligned frame, and for each of them `rx_chan` is the line index, always below 24.
- R4: In the bit time whose falling edge is frame bit position p, `tdm_dout` carries bit (7 − p mod 8) of the byte for the line channel of slot floor(p/8). Line channel n occupies `tx_bytes[8n+7:8n]`. `tdm_dout` changes only in the core cycle after a bus-clock rising edge.
- R5: During every bit of an unused slot, `tdm_dout` is 1 (idle byte 0xFF).
- R6: Until the first frame pulse is sampled, no byte is delivered and `tdm_dout` stays 1.
- R7: A frame pulse that is sampled high at a falling edge makes that edge frame bit position 0, wherever the counters stood. The partially collected byte is discarded, and the frame that follows is received and transmitted with the new alignment.
- R8: After alignment, frames that arrive without a pulse keep the established alignment by counting 256 bits per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tdm_clk | input | 1 | Bus clock level, synchronous to `clk` |
| tdm_fp | input | 1 | Frame pulse, sampled at bus-clock falling edges |
| tdm_din | input | 1 | Serial receive data |
| tdm_dout | output | 1 | Serial transmit data |
| tx_bytes | input | 192 | Transmit bytes, line channel n at bits 8n+7..8n |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_chan | output | 5 | Line channel index of the received byte |
| rx_data | output | 8 | Received byte |

## Verification
The hardest situation to bring about is a frame pulse arriving part-way through a timeslot that carries payload. In that case the bits already collected must be dropped, and both directions must realign at once. The bench gets there by cutting a frame short at bit 45, in the middle of a used slot, and at bit 100, inside an unused slot, and then starting a new pulsed frame. It checks every delivered byte and every transmitted bit of the frame that follows. It also runs a frame with no pulse, to show that the bit count alone holds the alignment.

// File: rtl/tdm_adapter_pkg.sv
package tdm_adapter_pkg;

    localparam int SLOTS      = 32;
    localparam int SLOT_BITS  = 8;
    localparam int GROUP      = 4;
    localparam int LINE_CH    = SLOTS / GROUP * (GROUP - 1);
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int CH_W       = $clog2(SLOTS);
    localparam int TX_W       = LINE_CH * SLOT_BITS;
    localparam logic [SLOT_BITS-1:0] IDLE_BYTE = '1;

    // Linear frame bit position: slot in the high part, bit in the low part.
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitn;
    } frame_pos_t;

    typedef struct packed {
        logic                 valid;
        logic [CH_W-1:0]      chan;
        logic [SLOT_BITS-1:0] data;
    } rx_word_t;

    // One slot in every group of GROUP is left without payload.
    function automatic logic slot_used(input logic [SLOT_W-1:0] slot);
        return (int'(slot) % GROUP) != 0;
    endfunction

    function automatic logic [CH_W-1:0] slot_to_line(input logic [SLOT_W-1:0] slot);
        int s;
        s = int'(slot);
        return CH_W'((s / GROUP) * (GROUP - 1) + (s % GROUP) - 1);
    endfunction

endpackage

// File: rtl/tdm_bus_edge.sv
module tdm_bus_edge (
    input  logic clk,
    input  logic rst,
    input  logic bus_clk,
    output logic bus_rise,
    output logic bus_fall
);
    logic bus_clk_q;

    always_ff @(posedge clk) begin
        if (rst) bus_clk_q <= 1'b0;
        else     bus_clk_q <= bus_clk;
    end

    assign bus_rise =  bus_clk & ~bus_clk_q;
    assign bus_fall = ~bus_clk &  bus_clk_q;
endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer
    import tdm_adapter_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_fall,
    input  logic       fp_in,
    input  logic       din,
    output frame_pos_t pos_o,
    output logic       locked_o,
    output rx_word_t   rx_word_o
);
    frame_pos_t                pos_q, pos_next;
    logic                      locked_q;
    logic [SLOT_BITS-1:0]      shift_q, shift_next;
    rx_word_t                  word_q;

    always_comb begin
        pos_next   = fp_in ? frame_pos_t'('0) : frame_pos_t'(pos_q + 1'b1);
        shift_next = {shift_q[SLOT_BITS-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '1;
            locked_q <= 1'b0;
            shift_q  <= '0;
            word_q   <= '0;
        end else begin
            word_q.valid <= 1'b0;
            if (bus_fall) begin
                pos_q   <= pos_next;
                shift_q <= shift_next;
                if (fp_in) locked_q <= 1'b1;
                if ((locked_q || fp_in) && (pos_next.bitn == BIT_W'(SLOT_BITS - 1))
                        && slot_used(pos_next.slot)) begin
                    word_q.valid <= 1'b1;
                    word_q.chan  <= slot_to_line(pos_next.slot);
                    word_q.data  <= shift_next;
                end
            end
        end
    end

    assign pos_o     = pos_q;
    assign locked_o  = locked_q;
    assign rx_word_o = word_q;

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        word_q.valid |=> !word_q.valid);

    assert_chan_range_R3: assert property (@(posedge clk) disable iff (rst)
        word_q.valid |-> (int'(word_q.chan) < LINE_CH));

    assert_quiet_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        !locked_q |-> !word_q.valid);
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
    import tdm_adapter_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_rise,
    input  frame_pos_t      pos_i,
    input  logic            locked_i,
    input  logic [TX_W-1:0] tx_bytes,
    output logic            dout
);
    frame_pos_t           tx_pos;
    logic [SLOT_BITS-1:0] cur_byte;
    logic                 dout_q;

    // The bit driven now is sampled by the far end at the next falling edge.
    always_comb begin
        tx_pos   = frame_pos_t'(pos_i + 1'b1);
        cur_byte = IDLE_BYTE;
        if (slot_used(tx_pos.slot))
            cur_byte = tx_bytes[int'(slot_to_line(tx_pos.slot)) * SLOT_BITS +: SLOT_BITS];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b1;
        end else if (bus_rise) begin
            dout_q <= locked_i ? cur_byte[BIT_W'(SLOT_BITS - 1) - tx_pos.bitn] : 1'b1;
        end
    end

    assign dout = dout_q;

    assert_edge_only_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_rise |=> $stable(dout_q));

    assert_unused_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rise && !slot_used(tx_pos.slot)) |=> dout_q);

    assert_idle_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> dout_q);
endmodule

// File: rtl/tdm_chan_adapter.sv
module tdm_chan_adapter
    import tdm_adapter_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tdm_clk,
    input  logic                 tdm_fp,
    input  logic                 tdm_din,
    output logic                 tdm_dout,
    input  logic [TX_W-1:0]      tx_bytes,
    output logic                 rx_valid,
    output logic [CH_W-1:0]      rx_chan,
    output logic [SLOT_BITS-1:0] rx_data
);
    logic       bus_rise, bus_fall, locked;
    frame_pos_t pos;
    rx_word_t   rx_word;

    tdm_bus_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .bus_clk  (tdm_clk),
        .bus_rise (bus_rise),
        .bus_fall (bus_fall)
    );

    tdm_rx_deframer rx_i (
        .clk       (clk),
        .rst       (rst),
        .bus_fall  (bus_fall),
        .fp_in     (tdm_fp),
        .din       (tdm_din),
        .pos_o     (pos),
        .locked_o  (locked),
        .rx_word_o (rx_word)
    );

    tdm_tx_framer tx_i (
        .clk      (clk),
        .rst      (rst),
        .bus_rise (bus_rise),
        .pos_i    (pos),
        .locked_i (locked),
        .tx_bytes (tx_bytes),
        .dout     (tdm_dout)
    );

    assign rx_valid = rx_word.valid;
    assign rx_chan  = rx_word.chan;
    assign rx_data  = rx_word.data;
endmodule

// File: tb/tdm_chan_adapter_tb_top.sv
`timescale 1ns/1ps
module tdm_chan_adapter_tb_top;
    localparam int HALF = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tdm_clk = 1'b0;
    logic         tdm_fp = 1'b0;
    logic         tdm_din = 1'b0;
    logic         tdm_dout;
    logic [191:0] tx_bytes = '0;
    logic         rx_valid;
    logic [4:0]   rx_chan;
    logic [7:0]   rx_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int got_cnt [32];
    logic [7:0] got_dat [32];
    int got_total = 0;

    always #4 clk = ~clk;

    tdm_chan_adapter dut_i (
        .clk(clk), .rst(rst), .tdm_clk(tdm_clk), .tdm_fp(tdm_fp),
        .tdm_din(tdm_din), .tdm_dout(tdm_dout), .tx_bytes(tx_bytes),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt[rx_chan] = got_cnt[rx_chan] + 1;
            got_dat[rx_chan] = rx_data;
            got_total = got_total + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int line_slot(input int n);
        return n + n / 3 + 1;
    endfunction

    function automatic logic [7:0] rx_pat(input int s, input int f);
        if (f == 3) return 8'h00;
        return 8'((s * 53 + f * 29 + 60) % 256);
    endfunction

    function automatic logic [7:0] tx_pat(input int n, input int f);
        if (f == 2) return 8'h00;
        return 8'((n * 37 + f * 91 + 5) % 256);
    endfunction

    function automatic int tx_expect(input int p, input int f);
        int s = p / 8;
        if (s % 4 == 0) return 1;
        return int'(tx_pat(3 * (s / 4) + s % 4 - 1, f)[7 - p % 8]);
    endfunction

    task automatic drive_bit(input logic b, input logic fp, output logic d);
        @(negedge clk);
        tdm_clk = 1'b1; tdm_din = b; tdm_fp = fp;
        repeat (HALF) @(posedge clk);
        #1 d = tdm_dout;
        @(negedge clk);
        tdm_clk = 1'b0;
        repeat (HALF) @(posedge clk);
    endtask

    // Drives len bits of frame f. check_first: bit 0 follows an aligned frame.
    task automatic run_frame(input int f, input logic with_fp, input int len,
                             input logic check_first, input string req);
        logic d;
        for (int n = 0; n < 32; n++) got_cnt[n] = 0;
        got_total = 0;
        for (int n = 0; n < 24; n++) tx_bytes[n*8 +: 8] = tx_pat(n, f);
        for (int p = 0; p < len; p++) begin
            drive_bit(rx_pat(p / 8, f)[7 - p % 8], with_fp && (p == 0), d);
            if (p > 0 || check_first)
                check({req, " R4 R5 tx bit"}, int'(d), tx_expect(p, f));
        end
        if (len == 256) begin
            check({req, " R3 delivered count"}, got_total, 24);
            for (int n = 0; n < 24; n++) begin
                check({req, " R3 one byte per line"}, got_cnt[n], 1);
                check({req, " R2 rx byte"}, int'(got_dat[n]), int'(rx_pat(line_slot(n), f)));
            end
        end
    endtask

    initial begin
        logic d;
        repeat (5) @(posedge clk);
        #1;
        check("R1 reset dout", int'(tdm_dout), 1);
        check("R1 reset rx_valid", int'(rx_valid), 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check("R1 after reset dout", int'(tdm_dout), 1);
        check("R1 after reset rx_valid", int'(rx_valid), 0);

        // R6: no pulse yet, nothing delivered and line idle
        got_total = 0;
        for (int n = 0; n < 24; n++) tx_bytes[n*8 +: 8] = 8'h00;
        for (int p = 0; p < 300; p++) begin
            drive_bit(rx_pat(p / 8, 9)[7 - p % 8], 1'b0, d);
            check("R6 idle before pulse", int'(d), 1);
        end
        check("R6 no delivery before pulse", got_total, 0);

        run_frame(0, 1'b1, 256, 1'b1, "R2 first frame");
        run_frame(1, 1'b1, 256, 1'b1, "R3 frame 1");
        run_frame(2, 1'b1, 256, 1'b1, "R4 tx zeros");
        run_frame(3, 1'b1, 256, 1'b1, "R2 rx zeros");
        run_frame(4, 1'b0, 256, 1'b1, "R8 no pulse");
        // R7: early pulse inside an unused slot
        run_frame(5, 1'b1, 100, 1'b1, "R7 partial unused");
        run_frame(6, 1'b1, 256, 1'b0, "R7 realigned A");
        run_frame(7, 1'b0, 256, 1'b1, "R8 after realign");
        // R7: early pulse in the middle of a used slot
        run_frame(8, 1'b1, 45, 1'b1, "R7 partial used");
        run_frame(9, 1'b1, 256, 1'b0, "R7 realigned B");
        run_frame(10, 1'b1, 256, 1'b1, "R7 steady");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule